// File: doc/BRIEF.md
# MSI Vector Status and Mask Aggregator

This block gathers message-signalled interrupt events arriving at a PCIe root port and turns them into interrupt levels for the host. The vectors are split into eight groups of 32. Each group keeps three 32-bit registers: an enable word, a mask word and a sticky status word. An incoming event names a group and a bit. If that vector is enabled, the event sets the matching status bit.

Status bits are flags, not counters. A second event on a bit that is already set leaves nothing extra behind. The mask only gates signalling. A masked vector still records its event, and it raises its group line as soon as the mask bit is removed.

Each group drives a level output. That output is high while any status bit in the group is set, enabled and unmasked. The host line is the OR of all group lines. Software uses a small register port: it reads and writes the enable and mask words, reads the status word, and clears status bits by writing ones.

Top module: `msiagg_top`

## Requirements
- R1: After a synchronous reset, every enable, mask and status word reads zero, and `group_irq` and `host_irq` are low.
- R2: An event pulse (`msi_valid` high for one cycle, `msi_group` 3 bits, `msi_vector` 5 bits) on an enabled vector sets status bit `msi_vector` of group `msi_group`. The bit is readable from the next cycle.
- R3: An event on a status bit that is already set records nothing further: a single write-one-to-clear of that bit leaves it zero, and the group line drops.
- R4: A write to a status word clears each bit written as one and leaves each bit written as zero unchanged.
- R5: When a status clear and a new event for the same bit fall in the same cycle, the bit ends set.
- R6: An event on a masked, enabled vector sets its status bit while the group line stays low. Clearing the mask bit raises the group line in the cycle after the write.
- R7: An event on a vector whose enable bit is zero is discarded and leaves status unchanged.
- R8: `group_irq[g]` is high exactly when group g has a bit that is set in status, set in enable and clear in mask. `host_irq` is the OR of all group lines. Clearing an enable bit hides a set status bit without clearing it.
- R9: The register address is {group[2:0], select[1:0]}. Select 0 is enable (read/write), 1 is mask (read/write), 2 is status (read, write one to clear), and 3 is reserved: it reads zero and ignores writes.
- R10: After software clears a status bit, a later event on that vector sets it again and raises the group line again.
- R11: Groups are independent: an event or register write addressed to one group changes no other group's registers or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | One-cycle event strobe |
| msi_group | input | 3 | Group index of the event |
| msi_vector | input | 5 | Bit index of the event inside its group |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {group, select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| group_irq | output | 8 | Per-group interrupt levels |
| host_irq | output | 1 | Combined host interrupt level |

## Verification
A status bit that is lost or held wrongly shows in two places. It appears in the status read-back on the first cycle after the event or the clear. It also appears in the group line during that same cycle, because the lines are combinational from the registers. A mask or enable word that is corrupted shows up on the next event, or when a set bit is unmasked, as a group line that is high or low against expectation. An event that lands in the wrong group shows up in the other group's status word at once.

// File: rtl/msiagg_pkg.sv
package msiagg_pkg;
    localparam int NUM_GROUPS    = 8;
    localparam int VEC_PER_GROUP = 32;
    localparam int GRP_W         = $clog2(NUM_GROUPS);
    localparam int VEC_W         = $clog2(VEC_PER_GROUP);
    localparam int SEL_W         = 2;
    localparam int ADDR_W        = GRP_W + SEL_W;
    localparam int DATA_W        = VEC_PER_GROUP;

    typedef enum logic [SEL_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [GRP_W-1:0] grp;
        logic [VEC_W-1:0] vec;
    } msi_req_t;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        reg_sel_e         sel;
    } reg_addr_t;

    function automatic logic [DATA_W-1:0] vec_onehot(input logic [VEC_W-1:0] idx);
        logic [DATA_W-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/msiagg_decode.sv
module msiagg_decode
    import msiagg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  msi_req_t              msi,
    input  logic                  reg_we,
    input  reg_addr_t             addr,
    output logic [NUM_GROUPS-1:0] msi_hit,
    output logic [NUM_GROUPS-1:0] en_we,
    output logic [NUM_GROUPS-1:0] mask_we,
    output logic [NUM_GROUPS-1:0] clr_we
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
        logic sel_grp;
        assign sel_grp    = reg_we && (addr.grp == GRP_W'(g));
        assign msi_hit[g] = msi.valid && (msi.grp == GRP_W'(g));
        assign en_we[g]   = sel_grp && (addr.sel == SEL_ENABLE);
        assign mask_we[g] = sel_grp && (addr.sel == SEL_MASK);
        assign clr_we[g]  = sel_grp && (addr.sel == SEL_STATUS);
    end

    AST_ONE_GROUP_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(msi_hit)); // R11
    AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({en_we, mask_we, clr_we}) <= 1); // R9
endmodule

// File: rtl/msiagg_group.sv
module msiagg_group
    import msiagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msi_hit,
    input  logic [VEC_W-1:0]  msi_idx,
    input  logic              en_we,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] enable_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] status_q,
    output logic              irq
);
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] status_nxt;

    always_comb begin
        set_vec    = (msi_hit && enable_q[msi_idx]) ? vec_onehot(msi_idx) : '0;
        clr_vec    = clr_we ? wdata : '0;
        // set applied after clear so a same-cycle event survives
        status_nxt = (status_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            mask_q   <= '0;
            status_q <= '0;
        end else begin
            if (en_we)   enable_q <= wdata;
            if (mask_we) mask_q   <= wdata;
            status_q <= status_nxt;
        end
    end

    assign irq = |(status_q & ~mask_q & enable_q);

    AST_ENABLED_SETS: assert property (@(posedge clk) disable iff (rst)
        (msi_hit && enable_q[msi_idx]) |=> status_q[$past(msi_idx)]); // R2
    AST_DISABLED_DROPS: assert property (@(posedge clk) disable iff (rst)
        (msi_hit && !enable_q[msi_idx] && !status_q[msi_idx]) |=> !status_q[$past(msi_idx)]); // R7
    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (rst)
        !msi_hit |=> ((status_q & ~$past(status_q)) == '0)); // R4
    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> (($past(status_q) & ~status_q) == '0)); // R4
    AST_SINGLE_NEW_BIT: assert property (@(posedge clk) disable iff (rst)
        msi_hit |=> ($countones(status_q & ~$past(status_q)) <= 1)); // R3
endmodule

// File: rtl/msiagg_top.sv
module msiagg_top
    import msiagg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  msi_valid,
    input  logic [GRP_W-1:0]      msi_group,
    input  logic [VEC_W-1:0]      msi_vector,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_GROUPS-1:0] group_irq,
    output logic                  host_irq
);
    msi_req_t  msi;
    reg_addr_t addr;

    assign msi  = '{valid: msi_valid, grp: msi_group, vec: msi_vector};
    assign addr = reg_addr_t'(reg_addr);

    logic [NUM_GROUPS-1:0] msi_hit, en_we, mask_we, clr_we;
    logic [DATA_W-1:0]     enable_w [NUM_GROUPS];
    logic [DATA_W-1:0]     mask_w   [NUM_GROUPS];
    logic [DATA_W-1:0]     status_w [NUM_GROUPS];

    msiagg_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .msi     (msi),
        .reg_we  (reg_we),
        .addr    (addr),
        .msi_hit (msi_hit),
        .en_we   (en_we),
        .mask_we (mask_we),
        .clr_we  (clr_we)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        msiagg_group u_group (
            .clk      (clk),
            .rst      (rst),
            .msi_hit  (msi_hit[g]),
            .msi_idx  (msi.vec),
            .en_we    (en_we[g]),
            .mask_we  (mask_we[g]),
            .clr_we   (clr_we[g]),
            .wdata    (reg_wdata),
            .enable_q (enable_w[g]),
            .mask_q   (mask_w[g]),
            .status_q (status_w[g]),
            .irq      (group_irq[g])
        );
    end

    always_comb begin
        unique case (addr.sel)
            SEL_ENABLE: reg_rdata = enable_w[addr.grp];
            SEL_MASK:   reg_rdata = mask_w[addr.grp];
            SEL_STATUS: reg_rdata = status_w[addr.grp];
            default:    reg_rdata = '0;
        endcase
    end

    assign host_irq = |group_irq;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (group_irq == '0)); // R1
    AST_IDLE_LINES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!msi_valid && !reg_we) |=> $stable(group_irq)); // R8
    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr.sel == SEL_RSVD) |-> (reg_rdata == '0)); // R9
endmodule

// File: tb/msiagg_top_test.sv
module msiagg_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        msi_valid;
    logic [2:0]  msi_group;
    logic [4:0]  msi_vector;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  group_irq;
    logic        host_irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    msiagg_top uut (
        .clk(clk), .rst(rst),
        .msi_valid(msi_valid), .msi_group(msi_group), .msi_vector(msi_vector),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .group_irq(group_irq), .host_irq(host_irq)
    );

    localparam logic [1:0] S_EN = 2'd0, S_MASK = 2'd1, S_STAT = 2'd2, S_RSVD = 2'd3;

    function automatic logic [4:0] ad(input int g, input logic [1:0] s);
        return {3'(g), s};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic msi(input int g, input int v);
        @(negedge clk);
        msi_valid = 1'b1; msi_group = 3'(g); msi_vector = 5'(v);
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), d);
            chk("R1", $sformatf("reg %0d after reset", a), d, 32'h0);
        end
        chk("R1", "group_irq after reset", {24'h0, group_irq}, 32'h0);
        chk("R1", "host_irq after reset", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        wr(ad(2, S_EN), 32'hFFFF_FFFF);
        rd(ad(2, S_EN), d);
        chk("R9", "enable readback", d, 32'hFFFF_FFFF);
        msi(2, 5);
        rd(ad(2, S_STAT), d);
        chk("R2", "status after event", d, 32'h20);
        chk("R8", "group_irq after event", {24'h0, group_irq}, 32'h04);
        chk("R8", "host_irq after event", {31'h0, host_irq}, 32'h1);
        wr(ad(2, S_STAT), 32'h20);
        rd(ad(2, S_STAT), d);
        chk("R4", "status after clear", d, 32'h0);
        chk("R8", "host_irq after clear", {31'h0, host_irq}, 32'h0);
    endtask

    task automatic t_dup();
        logic [31:0] d;
        msi(2, 9);
        msi(2, 9);
        rd(ad(2, S_STAT), d);
        chk("R3", "status after two events", d, 32'h200);
        wr(ad(2, S_STAT), 32'h200);
        rd(ad(2, S_STAT), d);
        chk("R3", "status after one clear", d, 32'h0);
        chk("R3", "group_irq after one clear", {24'h0, group_irq}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        msi(2, 1);
        msi(2, 3);
        wr(ad(2, S_STAT), 32'h2);
        rd(ad(2, S_STAT), d);
        chk("R4", "partial clear", d, 32'h8);
        wr(ad(2, S_STAT), 32'h0);
        rd(ad(2, S_STAT), d);
        chk("R4", "zero write keeps status", d, 32'h8);
        wr(ad(2, S_STAT), 32'h8);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        msi(2, 7);
        @(negedge clk);
        msi_valid = 1'b1; msi_group = 3'd2; msi_vector = 5'd7;
        reg_we = 1'b1; reg_addr = ad(2, S_STAT); reg_wdata = 32'h80;
        @(negedge clk);
        msi_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        rd(ad(2, S_STAT), d);
        chk("R5", "set beats clear", d, 32'h80);
        wr(ad(2, S_STAT), 32'h80);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(ad(2, S_MASK), 32'h10);
        msi(2, 4);
        rd(ad(2, S_STAT), d);
        chk("R6", "masked status latches", d, 32'h10);
        chk("R6", "masked group_irq low", {24'h0, group_irq}, 32'h0);
        wr(ad(2, S_MASK), 32'h0);
        chk("R6", "unmask raises group_irq", {24'h0, group_irq}, 32'h04);
        wr(ad(2, S_STAT), 32'h10);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        msi(5, 3);
        rd(ad(5, S_STAT), d);
        chk("R7", "disabled group discards", d, 32'h0);
        wr(ad(2, S_EN), 32'hFFFF_F7FF);
        msi(2, 11);
        rd(ad(2, S_STAT), d);
        chk("R7", "disabled vector discards", d, 32'h0);
        chk("R7", "group_irq after discard", {24'h0, group_irq}, 32'h0);
        wr(ad(2, S_EN), 32'hFFFF_FFFF);
    endtask

    task automatic t_refire();
        logic [31:0] d;
        msi(2, 6);
        wr(ad(2, S_STAT), 32'h40);
        chk("R10", "irq low after clear", {31'h0, host_irq}, 32'h0);
        msi(2, 6);
        rd(ad(2, S_STAT), d);
        chk("R10", "status set again", d, 32'h40);
        chk("R10", "irq raised again", {24'h0, group_irq}, 32'h04);
        wr(ad(2, S_STAT), 32'h40);
    endtask

    task automatic t_groups();
        logic [31:0] d;
        wr(ad(0, S_EN), 32'hFFFF_FFFF);
        wr(ad(7, S_EN), 32'hFFFF_FFFF);
        msi(7, 31);
        rd(ad(0, S_STAT), d);
        chk("R11", "group 0 untouched", d, 32'h0);
        rd(ad(7, S_STAT), d);
        chk("R11", "group 7 status", d, 32'h8000_0000);
        chk("R11", "only group 7 line", {24'h0, group_irq}, 32'h80);
        msi(0, 0);
        chk("R8", "two group lines", {24'h0, group_irq}, 32'h81);
        wr(ad(7, S_RSVD), 32'hFFFF_FFFF);
        rd(ad(7, S_RSVD), d);
        chk("R9", "reserved reads zero", d, 32'h0);
        rd(ad(7, S_EN), d);
        chk("R9", "reserved write ignored", d, 32'hFFFF_FFFF);
        wr(ad(7, S_EN), 32'h0);
        chk("R8", "enable clear hides line", {24'h0, group_irq}, 32'h01);
        rd(ad(7, S_STAT), d);
        chk("R8", "hidden status kept", d, 32'h8000_0000);
        wr(ad(0, S_STAT), 32'h1);
        chk("R8", "host_irq low", {31'h0, host_irq}, 32'h0);
    endtask

    initial begin
        rst = 1'b1; msi_valid = 1'b0; msi_group = '0; msi_vector = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dup();
        t_w1c();
        t_set_wins();
        t_mask();
        t_disabled();
        t_refire();
        t_groups();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule